// File: doc/BRIEF.md
# Shared-Comparator Thermal Watchdog

This block watches a set of latched temperature readings and raises an interrupt when any of them leaves its programmed window, or when the spread between a chosen group of sensors leaves its own window. The readings, the per-sensor limits, the spread limits and the masks arrive as plain inputs. Sensor acquisition and register decoding live elsewhere.

All arithmetic goes through one magnitude comparator, built around a single subtractor. A sequencer walks that comparator through a fixed list of checks. The list starts with a snapshot of the readings. It then finds the largest and smallest reading among the sensors selected for the spread check, forms their difference, and tests every sensor against its upper and then its lower limit. It ends by testing the spread against its upper and then its lower bound.

Each failed check sets a sticky flag in the alert-type register. The host clears a flag by writing a one to it. The interrupt line is the OR of the flags that the interrupt mask enables.

Top module: `thermal_watchdog`

## Requirements
- R1: For sensor i, type bit 2*i is set when the snapshot reading is strictly greater than that sensor's upper limit. A reading equal to the limit sets nothing.
- R2: For sensor i, type bit 2*i+1 is set when the snapshot reading is strictly less than that sensor's lower limit. A reading equal to the limit sets nothing.
- R3: `offset_o` holds the largest minus the smallest snapshot reading among the sensors whose bit is set in `ofs_mask_i`. It is zero when fewer than two sensors are selected.
- R4: Type bit 2*NUM_SENS is set when at least two sensors are selected and the spread is strictly greater than `ofs_hi_i`.
- R5: Type bit 2*NUM_SENS+1 is set when at least two sensors are selected and the spread is strictly less than `ofs_lo_i`. With fewer than two sensors selected, this bit is never set.
- R6: A type bit stays set until a cycle in which the matching `clr_i` bit is one. If a check sets a bit in the same cycle that clears it, the set wins.
- R7: `irq_o` is registered. It equals the OR of `type_o` ANDed with the value `irq_mask_i` had in the previous cycle.
- R8: The comparator performs one check per cycle, so at most one type bit rises per cycle. A scan lasts 4*NUM_SENS+4 cycles in this order: snapshot, max/min search (2 per sensor), difference, limit checks (upper then lower, per sensor in index order), spread upper, spread lower. The first scan's snapshot is taken on the first clock edge after reset is released, and sensor 0's upper check lands on the (2*NUM_SENS+3)-th edge.
- R9: Readings are sampled only in the snapshot cycle. A reading that changes during a scan affects no check until the next scan.
- R10: While `rst` is high, `type_o`, `irq_o` and `offset_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | NUM_SENS*TW | Latched readings, sensor i at bits [i*TW +: TW] |
| thr_hi_i | input | NUM_SENS*TW | Upper limit per sensor, same packing |
| thr_lo_i | input | NUM_SENS*TW | Lower limit per sensor, same packing |
| ofs_hi_i | input | TW | Upper bound on the spread |
| ofs_lo_i | input | TW | Lower bound on the spread |
| ofs_mask_i | input | NUM_SENS | Sensors included in the spread |
| irq_mask_i | input | 2*NUM_SENS+2 | Interrupt enable per type bit |
| clr_i | input | 2*NUM_SENS+2 | Write-one-to-clear strobe per type bit |
| irq_o | output | 1 | Level interrupt |
| type_o | output | 2*NUM_SENS+2 | Sticky alert-type flags |
| offset_o | output | TW | Spread from the last completed scan |

## Verification
The checker enforces the following on every cycle: the interrupt line against the masked flags, stickiness of flags under clear strobes, at most one newly risen flag per cycle, and that any newly risen spread flag is backed by the spread value and bound of the previous cycle. Other behaviour only the bench scenarios can show. This covers the exact scan length and check order, snapshot isolation against a reading that changes mid-scan, the strict-inequality behaviour at equality, and the suppression of spread alerts when fewer than two sensors are selected. The bench shows these through a sweep over every spread mask crossed with boundary and mixed reading patterns.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    PH_SNAP = 3'd0,
    PH_EXT  = 3'd1,
    PH_DIFF = 3'd2,
    PH_THR  = 3'd3,
    PH_OHI  = 3'd4,
    PH_OLO  = 3'd5
  } phase_e;
endpackage

// File: rtl/tw_cmp.sv
// Single magnitude comparator built on one subtractor.
module tw_cmp #(
  parameter int TW = 16
) (
  input  logic [TW-1:0] a_i,
  input  logic [TW-1:0] b_i,
  output logic          gt_o,
  output logic          lt_o
);
  logic [TW:0] diff;

  always_comb begin
    diff = {1'b0, a_i} - {1'b0, b_i};
    lt_o = diff[TW];
    gt_o = !diff[TW] && (|diff[TW-1:0]);
  end
endmodule

// File: rtl/tw_seq.sv
// Scan sequencer: walks the shared comparator through a fixed check list.
module tw_seq
  import tw_pkg::*;
#(
  parameter int NUM_SENS = 4,
  localparam int IW = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output phase_e        phase_o,
  output logic [IW-1:0] idx_o,
  output logic          sub_o
);
  localparam logic [IW-1:0] LAST = IW'(NUM_SENS - 1);

  phase_e        phase_q;
  logic [IW-1:0] idx_q;
  logic          sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_SNAP;
      idx_q   <= '0;
      sub_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_SNAP: begin
          phase_q <= PH_EXT;
          idx_q   <= '0;
          sub_q   <= 1'b0;
        end
        PH_EXT, PH_THR: begin
          if (!sub_q) begin
            sub_q <= 1'b1;
          end else begin
            sub_q <= 1'b0;
            if (idx_q == LAST) begin
              idx_q   <= '0;
              phase_q <= (phase_q == PH_EXT) ? PH_DIFF : PH_OHI;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        PH_DIFF: begin
          phase_q <= PH_THR;
          idx_q   <= '0;
          sub_q   <= 1'b0;
        end
        PH_OHI:  phase_q <= PH_OLO;
        default: phase_q <= PH_SNAP;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign sub_o   = sub_q;
endmodule

// File: rtl/tw_alert.sv
// Sticky alert-type register with write-one-to-clear and masked level interrupt.
module tw_alert #(
  parameter int NT = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] set_i,
  input  logic [NT-1:0] clr_i,
  input  logic [NT-1:0] irq_mask_i,
  output logic [NT-1:0] type_o,
  output logic          irq_o
);
  logic [NT-1:0] type_q, type_d;
  logic          irq_q;

  always_comb type_d = (type_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      type_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      type_q <= type_d;
      irq_q  <= |(type_d & irq_mask_i);
    end
  end

  assign type_o = type_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/thermal_watchdog.sv
module thermal_watchdog
  import tw_pkg::*;
#(
  parameter int NUM_SENS = 4,
  parameter int TW       = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_SENS*TW-1:0] temp_i,
  input  logic [NUM_SENS*TW-1:0] thr_hi_i,
  input  logic [NUM_SENS*TW-1:0] thr_lo_i,
  input  logic [TW-1:0]          ofs_hi_i,
  input  logic [TW-1:0]          ofs_lo_i,
  input  logic [NUM_SENS-1:0]    ofs_mask_i,
  input  logic [2*NUM_SENS+1:0]  irq_mask_i,
  input  logic [2*NUM_SENS+1:0]  clr_i,
  output logic                   irq_o,
  output logic [2*NUM_SENS+1:0]  type_o,
  output logic [TW-1:0]          offset_o
);
  localparam int NT = 2 * NUM_SENS + 2;
  localparam int IW = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1;
  localparam int CW = $clog2(NUM_SENS + 1) + 1;
  localparam int OHI_BIT = 2 * NUM_SENS;
  localparam int OLO_BIT = 2 * NUM_SENS + 1;

  phase_e        phase;
  logic [IW-1:0] idx;
  logic          sub;

  logic [TW-1:0] temp_a [NUM_SENS];
  logic [TW-1:0] hi_a   [NUM_SENS];
  logic [TW-1:0] lo_a   [NUM_SENS];
  logic [TW-1:0] snap_q [NUM_SENS];

  logic [TW-1:0] mx_q, mn_q, ofs_q;
  logic [CW-1:0] cnt_q;
  logic          pair_ok;

  logic [TW-1:0] cmp_a, cmp_b, cur;
  logic          cmp_gt, cmp_lt;
  logic [NT-1:0] set_vec;

  for (genvar g = 0; g < NUM_SENS; g++) begin : g_unpack
    assign temp_a[g] = temp_i[g*TW +: TW];
    assign hi_a[g]   = thr_hi_i[g*TW +: TW];
    assign lo_a[g]   = thr_lo_i[g*TW +: TW];
  end

  tw_seq #(.NUM_SENS(NUM_SENS)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .phase_o(phase),
    .idx_o  (idx),
    .sub_o  (sub)
  );

  assign cur     = snap_q[idx];
  assign pair_ok = (cnt_q >= CW'(2));

  // Operand selection for the shared comparator
  always_comb begin
    cmp_a = '0;
    cmp_b = '0;
    case (phase)
      PH_EXT: begin
        cmp_a = cur;
        cmp_b = sub ? mn_q : mx_q;
      end
      PH_THR: begin
        cmp_a = cur;
        cmp_b = sub ? lo_a[idx] : hi_a[idx];
      end
      PH_OHI: begin
        cmp_a = ofs_q;
        cmp_b = ofs_hi_i;
      end
      PH_OLO: begin
        cmp_a = ofs_q;
        cmp_b = ofs_lo_i;
      end
      default: ;
    endcase
  end

  tw_cmp #(.TW(TW)) u_cmp (
    .a_i (cmp_a),
    .b_i (cmp_b),
    .gt_o(cmp_gt),
    .lt_o(cmp_lt)
  );

  // Alert pulses: at most one per cycle
  always_comb begin
    set_vec = '0;
    case (phase)
      PH_THR: begin
        if (!sub && cmp_gt) set_vec[2*int'(idx)]     = 1'b1;
        if (sub && cmp_lt)  set_vec[2*int'(idx) + 1] = 1'b1;
      end
      PH_OHI: if (pair_ok && cmp_gt) set_vec[OHI_BIT] = 1'b1;
      PH_OLO: if (pair_ok && cmp_lt) set_vec[OLO_BIT] = 1'b1;
      default: ;
    endcase
  end

  // Snapshot, extreme search and spread
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SENS; i++) snap_q[i] <= '0;
      mx_q  <= '0;
      mn_q  <= '1;
      cnt_q <= '0;
      ofs_q <= '0;
    end else begin
      case (phase)
        PH_SNAP: begin
          for (int i = 0; i < NUM_SENS; i++) snap_q[i] <= temp_a[i];
          mx_q  <= '0;
          mn_q  <= '1;
          cnt_q <= '0;
        end
        PH_EXT: begin
          if (ofs_mask_i[idx]) begin
            if (!sub) begin
              if (cmp_gt) mx_q <= cur;
            end else begin
              if (cmp_lt) mn_q <= cur;
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_DIFF: ofs_q <= pair_ok ? (mx_q - mn_q) : '0;
        default: ;
      endcase
    end
  end

  tw_alert #(.NT(NT)) u_alert (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_vec),
    .clr_i     (clr_i),
    .irq_mask_i(irq_mask_i),
    .type_o    (type_o),
    .irq_o     (irq_o)
  );

  assign offset_o = ofs_q;
endmodule

// File: rtl/tw_chk.sv
module tw_chk #(
  parameter int NUM_SENS = 4,
  parameter int TW       = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2*NUM_SENS+1:0] type_o,
  input logic [2*NUM_SENS+1:0] irq_mask_i,
  input logic [2*NUM_SENS+1:0] clr_i,
  input logic                  irq_o,
  input logic [TW-1:0]         offset_o,
  input logic [TW-1:0]         ofs_hi_i,
  input logic [TW-1:0]         ofs_lo_i
);
  localparam int OHI_BIT = 2 * NUM_SENS;
  localparam int OLO_BIT = 2 * NUM_SENS + 1;

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(type_o & $past(irq_mask_i))); // R7

  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (($past(type_o) & ~$past(clr_i)) & ~type_o) == '0); // R6

  AST_ONE_NEW_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(type_o & ~$past(type_o))); // R8

  AST_OFS_HI_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (type_o[OHI_BIT] && !$past(type_o[OHI_BIT])) |-> ($past(offset_o) > $past(ofs_hi_i))); // R4

  AST_OFS_LO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (type_o[OLO_BIT] && !$past(type_o[OLO_BIT])) |-> ($past(offset_o) < $past(ofs_lo_i))); // R5
endmodule

bind thermal_watchdog tw_chk #(.NUM_SENS(NUM_SENS), .TW(TW)) u_tw_chk (
  .clk       (clk),
  .rst       (rst),
  .type_o    (type_o),
  .irq_mask_i(irq_mask_i),
  .clr_i     (clr_i),
  .irq_o     (irq_o),
  .offset_o  (offset_o),
  .ofs_hi_i  (ofs_hi_i),
  .ofs_lo_i  (ofs_lo_i)
);

// File: tb/tb_thermal_watchdog.sv
module tb_thermal_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int TW   = 16;
  localparam int NT   = 2 * NS + 2;
  localparam int SCAN = 4 * NS + 4;
  localparam int OFS_HI = 250;
  localparam int OFS_LO = 40;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NS*TW-1:0]  temp_i, thr_hi_i, thr_lo_i;
  logic [TW-1:0]     ofs_hi_i, ofs_lo_i;
  logic [NS-1:0]     ofs_mask_i;
  logic [NT-1:0]     irq_mask_i, clr_i;
  logic              irq_o;
  logic [NT-1:0]     type_o;
  logic [TW-1:0]     offset_o;

  logic [TW-1:0] tv [NS];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always_comb
    for (int i = 0; i < NS; i++) temp_i[i*TW +: TW] = tv[i];

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_watchdog #(.NUM_SENS(NS), .TW(TW)) dut (
    .clk(clk), .rst(rst), .temp_i(temp_i), .thr_hi_i(thr_hi_i), .thr_lo_i(thr_lo_i),
    .ofs_hi_i(ofs_hi_i), .ofs_lo_i(ofs_lo_i), .ofs_mask_i(ofs_mask_i),
    .irq_mask_i(irq_mask_i), .clr_i(clr_i), .irq_o(irq_o), .type_o(type_o),
    .offset_o(offset_o)
  );

  function automatic int hi_of(int i); return 800 + 10 * i; endfunction
  function automatic int lo_of(int i); return 200 + 5 * i;  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected type bits and spread, computed from the requirements
  task automatic expect_vals(input logic [NS-1:0] m, output logic [NT-1:0] e, output int ofs);
    int mx, mn, n;
    e = '0; mx = 0; mn = 65535; n = 0;
    for (int i = 0; i < NS; i++) begin
      if (int'(tv[i]) > hi_of(i)) e[2*i] = 1'b1;
      if (int'(tv[i]) < lo_of(i)) e[2*i+1] = 1'b1;
      if (m[i]) begin
        n++;
        if (int'(tv[i]) > mx) mx = int'(tv[i]);
        if (int'(tv[i]) < mn) mn = int'(tv[i]);
      end
    end
    ofs = (n >= 2) ? mx - mn : 0;
    if (n >= 2 && ofs > OFS_HI) e[NT-2] = 1'b1;
    if (n >= 2 && ofs < OFS_LO) e[NT-1] = 1'b1;
  endtask

  function automatic int pat(int p, int i);
    case (p)
      0: return hi_of(i);
      1: return hi_of(i) + 1;
      2: return lo_of(i);
      3: return lo_of(i) - 1;
      4: return 300 + 120 * i;
      5: return 500 + 20 * i;
      default: return (i == 0) ? hi_of(0) + 1 : (i == 1) ? lo_of(1) - 1 : (i == 2) ? 500 : 790;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NT-1:0] e;
    int eo;
    for (int i = 0; i < NS; i++) begin
      thr_hi_i[i*TW +: TW] = TW'(hi_of(i));
      thr_lo_i[i*TW +: TW] = TW'(lo_of(i));
      tv[i] = 16'd500;
    end
    tv[0]      = 16'd900;
    ofs_hi_i   = TW'(OFS_HI);
    ofs_lo_i   = TW'(OFS_LO);
    ofs_mask_i = '0;
    irq_mask_i = '1;
    clr_i      = '0;

    // R10: reset state
    tick(3);
    chk("R10 type", int'(type_o), 0);
    chk("R10 irq", int'(irq_o), 0);
    chk("R10 offset", int'(offset_o), 0);
    rst = 1'b0;

    // R9/R8: snapshot on edge 1, sensor 0 upper check on edge 11, lower on edge 12
    tick(3);
    tv[0] = 16'd100;
    tick(7);
    chk("R8 before first check", int'(type_o), 0);
    tick(1);
    chk("R1 sensor0 high at edge 11", int'(type_o[0]), 1);
    chk("R8 irq follows flag", int'(irq_o), 1);
    tick(1);
    chk("R9 mid-scan change unseen", int'(type_o[1]), 0);
    tick(19);
    chk("R8 lower not before next scan", int'(type_o[1]), 0);
    tick(1);
    chk("R2 sensor0 low at edge 32", int'(type_o[1]), 1);
    chk("R6 high flag sticky", int'(type_o[0]), 1);

    // Sweep: every spread mask crossed with boundary and mixed patterns
    for (int p = 0; p < 7; p++) begin
      for (int m = 0; m < (1 << NS); m++) begin
        for (int i = 0; i < NS; i++) tv[i] = TW'(pat(p, i));
        ofs_mask_i = NS'(m);
        irq_mask_i = NT'((p * 16 + m) * 173);
        clr_i = '1;
        tick(2 * SCAN);
        clr_i = '0;
        tick(2 * SCAN);
        expect_vals(NS'(m), e, eo);
        chk("R1 upper flags", int'({type_o[6], type_o[4], type_o[2], type_o[0]}),
            int'({e[6], e[4], e[2], e[0]}));
        chk("R2 lower flags", int'({type_o[7], type_o[5], type_o[3], type_o[1]}),
            int'({e[7], e[5], e[3], e[1]}));
        chk("R3 spread", int'(offset_o), eo);
        chk("R4 spread upper flag", int'(type_o[NT-2]), int'(e[NT-2]));
        chk("R5 spread lower flag", int'(type_o[NT-1]), int'(e[NT-1]));
        chk("R7 irq", int'(irq_o), int'(|(e & irq_mask_i)));
      end
    end

    // R6: flags survive removal of the cause, clear is per bit
    for (int i = 0; i < NS; i++) tv[i] = TW'(hi_of(i) + 1);
    ofs_mask_i = '0;
    irq_mask_i = NT'(1);
    clr_i = '1;
    tick(2 * SCAN);
    clr_i = '0;
    tick(2 * SCAN);
    for (int i = 0; i < NS; i++) tv[i] = 16'd500;
    tick(2 * SCAN);
    chk("R6 flags held without clear", int'(type_o), 'h55);
    clr_i = NT'(1);
    tick(1);
    clr_i = '0;
    tick(1);
    chk("R6 only bit 0 cleared", int'(type_o), 'h54);
    chk("R7 irq drops with enabled bit", int'(irq_o), 0);
    clr_i = '1;
    tick(1);
    clr_i = '0;
    tick(2 * SCAN);
    chk("R6 all cleared stays clear", int'(type_o), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule